// File: doc/BRIEF.md
# Segmented DAC Code Splitter

This block feeds a pair of 16-bit converters that are wired as the lower and upper halves of one wider sign-magnitude converter. On each sample strobe it takes one input code and forms the lower-segment word and the upper-segment word. The code's top bit picks the active segment and is sent to neither converter. The idle segment is parked at its boundary value: the lower word goes to all ones when the upper half is active, and the upper word goes to zero when the lower half is active. The analog sum of the two outputs then follows the input code.

Two input formats are accepted. In full mode the input is a 17-bit code and its low 16 bits feed the active segment directly. In padded mode a 16-bit code is shifted up by one place. The new low bit follows the 15 data bits when they are uniform, and otherwise comes from a separate input that can carry dither or an extra bit of precision. The two segments would both code bipolar zero, so the upper word gets one extra LSB. That addition saturates at all ones, so full scale cannot wrap. Both words and a valid flag are registered together.

Top module: `seg_dac_splitter`

## Requirements
- R1: While rst_n is low and after its release, lo_word and hi_word are 0 and out_valid is 0 until the first strobe has been registered.
- R2: out_valid is 1 exactly one clock after a cycle with in_valid high, and 0 otherwise. Both words change only on that clock and hold their values while in_valid is low.
- R3: The select bit is sample_in[16] when mode_full is 1 and sample_in[15] when mode_full is 0. When it is 0, hi_word is 16'h0000.
- R4: When the select bit is 1, lo_word is 16'hFFFF.
- R5: In full mode (mode_full = 1) with the select bit 0, lo_word equals sample_in[15:0].
- R6: In padded mode (mode_full = 0) the active payload is {sample_in[14:0], fill}, and sample_in[16] has no effect on either word.
- R7: In padded mode the fill bit is 1 when sample_in[14:0] is all ones and 0 when it is all zeros. Otherwise it equals ext_lsb.
- R8: With the select bit 1, hi_word is the active payload plus one, so it is never 0.
- R9: The upper-word addition saturates. A payload of 16'hFFFF gives hi_word 16'hFFFF, so the 17-bit input 0x1FFFF gives lo_word + hi_word = 131070.
- R10: In full mode, lo_word + hi_word equals the input code for every code from 0 to 131070, so the sum rises strictly across the zero crossing between codes 65535 and 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| mode_full | input | 1 | 1: 17-bit input, 0: 16-bit input padded by one low bit |
| sample_in | input | 17 | Input code (bits 15:0 only in padded mode) |
| ext_lsb | input | 1 | Extra low bit (dither or precision) for padded mode |
| lo_word | output | 16 | Lower-segment converter word |
| hi_word | output | 16 | Upper-segment converter word |
| out_valid | output | 1 | Pulses with each registered pair of words |

## Verification
Every result is due one clock after the strobe: both words and out_valid come from a single register stage, with no other register between the input and that stage. The bench changes the inputs on a falling edge and reads the outputs on the next falling edge, half a cycle after the capturing rising edge. Each check therefore sees the pair that belongs to the vector applied just before it. The hold check drops the strobe and changes the inputs. At the next falling edge it expects out_valid low and both words unchanged.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;
  localparam int SEG_W = 16;

  typedef enum logic {
    MODE_PADDED = 1'b0,
    MODE_FULL   = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/seg_code_former.sv
module seg_code_former
  import seg_split_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic         mode_full,
  input  logic [W:0]   sample,
  input  logic         ext_lsb,
  output logic         sel,
  output logic [W-1:0] payload
);
  localparam int DW = W - 1;

  function automatic logic fill_bit(input logic [DW-1:0] d, input logic ext);
    if (&d)      return 1'b1;
    else if (|d) return ext;
    else         return 1'b0;
  endfunction

  seg_mode_e mode;
  assign mode = seg_mode_e'(mode_full);

  always_comb begin
    if (mode == MODE_FULL) begin
      sel     = sample[W];
      payload = sample[W-1:0];
    end else begin
      sel     = sample[W-1];
      payload = {sample[DW-1:0], fill_bit(sample[DW-1:0], ext_lsb)};
    end
  end
endmodule

// File: rtl/seg_router.sv
module seg_router
  import seg_split_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic         sel,
  input  logic [W-1:0] payload,
  output logic [W-1:0] lo_d,
  output logic [W-1:0] hi_d
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    if (&v) return v;
    else    return v + 1'b1;
  endfunction

  always_comb begin
    if (sel) begin
      lo_d = '1;
      hi_d = sat_inc(payload);
    end else begin
      lo_d = payload;
      hi_d = '0;
    end
  end
endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg
  import seg_split_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] lo_d,
  input  logic [W-1:0] hi_d,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe;
      if (strobe) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end
  end

  assert_valid_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> valid_q);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!valid_q && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/seg_dac_splitter.sv
module seg_dac_splitter
  import seg_split_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         mode_full,
  input  logic [W:0]   sample_in,
  input  logic         ext_lsb,
  output logic [W-1:0] lo_word,
  output logic [W-1:0] hi_word,
  output logic         out_valid
);
  localparam int DW = W - 1;

  logic         upper_active;
  logic [W-1:0] payload;
  logic [W-1:0] lo_d;
  logic [W-1:0] hi_d;

  seg_code_former #(.W(W)) u_former (
    .mode_full (mode_full),
    .sample    (sample_in),
    .ext_lsb   (ext_lsb),
    .sel       (upper_active),
    .payload   (payload)
  );

  seg_router #(.W(W)) u_router (
    .sel     (upper_active),
    .payload (payload),
    .lo_d    (lo_d),
    .hi_d    (hi_d)
  );

  seg_out_reg #(.W(W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (in_valid),
    .lo_d    (lo_d),
    .hi_d    (hi_d),
    .lo_q    (lo_word),
    .hi_q    (hi_word),
    .valid_q (out_valid)
  );

  // The idle segment is parked at its boundary value.
  assert_lower_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !upper_active) |=> (hi_word == '0));
  assert_upper_parks_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upper_active) |=> (lo_word == '1));
  // The upper word carries the extra LSB, so it can never read zero.
  assert_upper_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upper_active) |=> (hi_word != '0));
  // A uniform data field fixes the fill bit.
  assert_fill_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_full && (&sample_in[DW-1:0])) |=> (lo_word[0] && (hi_word[0] || hi_word == '0)));
  assert_fill_zeros_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_full && !sample_in[W-1] && (sample_in[DW-1:0] == '0)) |=> (lo_word == '0));
endmodule

// File: tb/sim_seg_dac_splitter.sv
module sim_seg_dac_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode_full = 1'b1;
  logic [16:0] sample_in = '0;
  logic        ext_lsb = 1'b0;
  logic [15:0] lo_word;
  logic [15:0] hi_word;
  logic        out_valid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  seg_dac_splitter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_full(mode_full),
    .sample_in(sample_in), .ext_lsb(ext_lsb),
    .lo_word(lo_word), .hi_word(hi_word), .out_valid(out_valid)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected words for an effective 17-bit code c, computed arithmetically.
  function automatic int exp_lo(input int c);
    return (c < 65536) ? c : 65535;
  endfunction
  function automatic int exp_hi(input int c);
    if (c < 65536) return 0;
    if (c == 131071) return 65535;
    return c - 65535;
  endfunction

  task automatic apply(input logic m, input logic [16:0] s, input logic e);
    mode_full = m;
    sample_in = s;
    ext_lsb   = e;
    in_valid  = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 199000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int prev_sum;
    int sum;
    int c;
    int d;
    logic [15:0] held_lo;
    logic [15:0] held_hi;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 lo", int'(lo_word), 0);
    check("R1 hi", int'(hi_word), 0);
    check("R1 valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 lo after release", int'(lo_word), 0);

    // Full-mode sweep: R3 R4 R5 R8 R9 R10
    prev_sum = -1;
    for (int i = 0; i < 131072; i++) begin
      apply(1'b1, 17'(i), 1'b0);
      sum = int'(lo_word) + int'(hi_word);
      check("R2 valid", int'(out_valid), 1);
      if (i < 65536) begin
        check("R5 lo", int'(lo_word), exp_lo(i));
        check("R3 hi", int'(hi_word), 0);
      end else begin
        check("R4 lo", int'(lo_word), 65535);
        if (i == 131071) check("R9 hi saturate", int'(hi_word), 65535);
        else             check("R8 hi", int'(hi_word), exp_hi(i));
      end
      if (i == 131071) check("R9 sum at full scale", sum, prev_sum);
      else if (sum <= prev_sum) check("R10 monotonic", sum, prev_sum + 1);
      prev_sum = sum;
    end

    // Padded-mode windows around zero, the crossing and full scale: R6 R7
    for (int j = 0; j < 6144; j++) begin
      int s;
      logic e;
      logic f;
      s = (j < 2048) ? j : (j < 4096) ? (31744 + j - 2048) : (63488 + j - 4096);
      e = logic'(j[0] ^ j[1]);
      d = s & 32767;
      f = (d == 32767) ? 1'b1 : (d == 0) ? 1'b0 : e;
      c = (s << 1) | int'(f);
      apply(1'b0, {logic'(j[2]), 16'(s)}, e);
      check("R6/R7 lo", int'(lo_word), exp_lo(c));
      check("R6/R7 hi", int'(hi_word), exp_hi(c));
    end

    // Hold while strobe low: R2
    apply(1'b1, 17'h12345, 1'b0);
    held_lo = lo_word;
    held_hi = hi_word;
    in_valid  = 1'b0;
    sample_in = 17'h00007;
    @(negedge clk);
    check("R2 valid low", int'(out_valid), 0);
    check("R2 lo hold", int'(lo_word), int'(held_lo));
    check("R2 hi hold", int'(hi_word), int'(held_hi));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule